// File: doc/BRIEF.md
# Selectable Tick Prescaler

This block makes the counting enable for one timer channel. Two tick qualifiers arrive as single-cycle enables, both synchronous to the main clock. One runs at the system rate and one at a slow real-time rate. A select bit picks one of them. The chosen qualifier is then divided by a ratio taken from a 4-bit code. The ratio is not a plain power of two: codes 0 through 12 give ratios 1 through 13, and the three top codes give 16, 32 and 64. The result is a one-cycle pulse on `tick_out` for every N selected ticks, which the channel's counter uses as its step enable.

The divide counter starts over whenever the source select or the ratio code changes, and whenever the channel's counter-clear is high. A retune therefore never produces a shortened interval or two intervals merged into one. There is no data stream here: every pin is a plain level or a one-cycle strobe, so no handshake and no back-pressure apply.

Top module: `tick_prescaler`

## Requirements
- R1: `tick_out` is 0 while `rst_n` is low. After reset the stored configuration is source 0 with code 0.
- R2: With `src_sel` = 0, only `sys_tick_en` is counted. Pulses on `slow_tick_en` have no effect on `tick_out`.
- R3: With `src_sel` = 1, only `slow_tick_en` is counted. Pulses on `sys_tick_en` have no effect on `tick_out`.
- R4: A `div_code` value c from 0 to 12 divides the selected ticks by c+1.
- R5: A `div_code` of 13 divides by 16, 14 divides by 32 and 15 divides by 64.
- R6: With source 0, code 0 and `sys_tick_en` held high, `tick_out` is high on every cycle.
- R7: `tick_out` is high for exactly one cycle per N counted ticks. It is never high on two consecutive cycles unless N is 1.
- R8: In a cycle where `src_sel` or `div_code` differs from its value on the previous cycle, the count restarts from zero. The tick sampled in that cycle is not counted, and `tick_out` is 0 on the following cycle.
- R9: In a cycle where `cnt_clear` is high, the count restarts from zero. The tick sampled in that cycle is not counted, and `tick_out` is 0 on the following cycle.
- R10: `tick_out` goes high in the cycle that follows the clock edge sampling the N-th counted tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sys_tick_en | input | 1 | System-rate tick qualifier |
| slow_tick_en | input | 1 | Slow real-time-rate tick qualifier |
| src_sel | input | 1 | Source select: 0 system rate, 1 slow rate |
| div_code | input | 4 | Ratio code: 0..12 give code+1, 13 gives 16, 14 gives 32, 15 gives 64 |
| cnt_clear | input | 1 | Channel counter-clear; restarts the divide count |
| tick_out | output | 1 | One-cycle divided tick enable |

## Verification
On every cycle, the assertions check four things. The count stays below the active ratio. An idle selected qualifier never yields a tick on the next cycle. A clear or a configuration change suppresses the next tick. No two ticks come back to back when the ratio exceeds 1. The exact ratio that each of the sixteen codes produces, and the latency of one cycle, can only be shown by the bench's scenarios. The same holds for ignoring the unselected qualifier and for the new phase after a restart. For these, the bench compares `tick_out` against a cycle model on every cycle.

// File: rtl/tkd_pkg.sv
package tkd_pkg;
  localparam int CODE_W    = 4;
  localparam int LIN_LAST  = 12;
  localparam int MAX_RATIO = 64;
  localparam int RAT_W     = $clog2(MAX_RATIO + 1);
  localparam int CNT_W     = $clog2(MAX_RATIO);

  // Linear range c+1, then 16 << (c-13) for the top three codes.
  function automatic logic [RAT_W-1:0] code_ratio(input logic [CODE_W-1:0] c);
    if (c <= CODE_W'(LIN_LAST))
      return RAT_W'(c) + RAT_W'(1);
    else
      return RAT_W'(16) << (c - CODE_W'(LIN_LAST + 1));
  endfunction
endpackage

// File: rtl/tkd_src_pick.sv
module tkd_src_pick (
  input  logic src_sel,
  input  logic sys_tick_en,
  input  logic slow_tick_en,
  output logic tick_sel
);
  always_comb begin
    tick_sel = src_sel ? slow_tick_en : sys_tick_en;
  end
endmodule

// File: rtl/tkd_cfg_watch.sv
module tkd_cfg_watch
  import tkd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_sel,
  input  logic [CODE_W-1:0] div_code,
  output logic              restart,
  output logic [RAT_W-1:0]  ratio
);
  logic              prev_src_q;
  logic [CODE_W-1:0] prev_code_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_src_q  <= 1'b0;
      prev_code_q <= '0;
    end else begin
      prev_src_q  <= src_sel;
      prev_code_q <= div_code;
    end
  end

  always_comb begin
    restart = (src_sel != prev_src_q) || (div_code != prev_code_q);
    ratio   = code_ratio(div_code);
  end

  // R5
  ratio_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio >= RAT_W'(1)) && (ratio <= RAT_W'(MAX_RATIO)));
endmodule

// File: rtl/tkd_div_cnt.sv
module tkd_div_cnt
  import tkd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_in,
  input  logic             restart,
  input  logic             clear,
  input  logic [RAT_W-1:0] ratio,
  output logic             tick_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             tick_q;
  logic             at_last;

  always_comb begin
    at_last = (RAT_W'(cnt_q) == (ratio - RAT_W'(1)));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (restart || clear) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (tick_in) begin
      if (at_last) begin
        cnt_q  <= '0;
        tick_q <= 1'b1;
      end else begin
        cnt_q  <= cnt_q + CNT_W'(1);
        tick_q <= 1'b0;
      end
    end else begin
      tick_q <= 1'b0;
    end
  end

  assign tick_o = tick_q;

  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |-> (RAT_W'(cnt_q) < ratio));

  // R2
  idle_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_in |=> !tick_q);

  // R7
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_q && (ratio != RAT_W'(1))) |=> !tick_q);

  // R9
  clear_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (!tick_q && (cnt_q == '0)));
endmodule

// File: rtl/tick_prescaler.sv
module tick_prescaler
  import tkd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sys_tick_en,
  input  logic              slow_tick_en,
  input  logic              src_sel,
  input  logic [CODE_W-1:0] div_code,
  input  logic              cnt_clear,
  output logic              tick_out
);
  logic             tick_sel;
  logic             restart;
  logic [RAT_W-1:0] ratio;

  tkd_src_pick u_pick (
    .src_sel      (src_sel),
    .sys_tick_en  (sys_tick_en),
    .slow_tick_en (slow_tick_en),
    .tick_sel     (tick_sel)
  );

  tkd_cfg_watch u_watch (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_sel  (src_sel),
    .div_code (div_code),
    .restart  (restart),
    .ratio    (ratio)
  );

  tkd_div_cnt u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_in (tick_sel),
    .restart (restart),
    .clear   (cnt_clear),
    .ratio   (ratio),
    .tick_o  (tick_out)
  );

  // R8
  cfg_change_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !tick_out);

  // R3
  slow_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel && !slow_tick_en) |=> !tick_out);
endmodule

// File: tb/tick_prescaler_bench.sv
module tick_prescaler_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sys_tick_en = 1'b0;
  logic       slow_tick_en = 1'b0;
  logic       src_sel = 1'b0;
  logic [3:0] div_code = 4'd0;
  logic       cnt_clear = 1'b0;
  logic       tick_out;

  int n_cmp = 0;
  int n_bad = 0;

  typedef struct {
    logic  exp;
    string req;
  } item_t;
  item_t sb_q[$];

  int         m_cnt = 0;
  logic       m_psrc = 1'b0;
  logic [3:0] m_pcode = 4'd0;

  always #2 clk = ~clk;

  tick_prescaler u_tick_prescaler (
    .clk (clk), .rst_n (rst_n), .sys_tick_en (sys_tick_en),
    .slow_tick_en (slow_tick_en), .src_sel (src_sel), .div_code (div_code),
    .cnt_clear (cnt_clear), .tick_out (tick_out)
  );

  function automatic int ref_ratio(input logic [3:0] c);
    if (c < 4'd13) return int'(c) + 1;
    case (c)
      4'd13:   return 16;
      4'd14:   return 32;
      default: return 64;
    endcase
  endfunction

  // Driver: sets inputs at the falling edge, models the next output, queues it.
  task automatic step(input logic sys, input logic slow, input logic src,
                      input logic [3:0] code, input logic clr, input string tag);
    logic chg;
    logic sel;
    logic e;
    sys_tick_en = sys; slow_tick_en = slow; src_sel = src;
    div_code = code; cnt_clear = clr;
    chg = (src != m_psrc) || (code != m_pcode);
    sel = src ? slow : sys;
    e = 1'b0;
    if (chg || clr) m_cnt = 0;
    else if (sel) begin
      if (m_cnt == ref_ratio(code) - 1) begin m_cnt = 0; e = 1'b1; end
      else m_cnt = m_cnt + 1;
    end
    m_psrc = src; m_pcode = code;
    sb_q.push_back('{exp: e, req: tag});
    @(negedge clk);
  endtask

  // Monitor: samples one ns after each rising edge.
  always @(posedge clk) begin
    #1;
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      n_cmp++;
      if (tick_out !== it.exp) begin
        n_bad++;
        $display("FAIL %s: tick_out=%b expected=%b at %0t", it.req, tick_out, it.exp, $time);
      end
    end
  end

  initial begin
    int wd;
    wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 100000) begin
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    n_cmp++;
    if (tick_out !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: tick_out=%b expected=0 in reset", tick_out);
    end
    rst_n = 1'b1;

    // R6: undivided system ticks
    for (int i = 0; i < 20; i++) step(1, 0, 0, 4'd0, 0, "R6");
    // R10: sparse system ticks, code 0
    for (int i = 0; i < 15; i++) step(i % 3 == 0, 0, 0, 4'd0, 0, "R10");
    // R4: linear codes, gapped tick patterns with slow-rate noise
    for (int c = 1; c <= 12; c++)
      for (int i = 0; i < 3 * (c + 1) + 4; i++)
        step((i % 3) != 1, i[0], 0, 4'(c), 0, "R4");
    // R5: top codes
    for (int c = 13; c <= 15; c++)
      for (int i = 0; i < 2 * ref_ratio(4'(c)) + 3; i++)
        step(1, 0, 0, 4'(c), 0, "R5");
    // R2: slow qualifier ignored on the system source
    for (int i = 0; i < 10; i++) step(0, 1, 0, 4'd2, 0, "R2");
    for (int i = 0; i < 12; i++) step(i[0], 1, 0, 4'd2, 0, "R2");
    // R3: slow source, system qualifier ignored
    for (int i = 0; i < 60; i++) step(1, (i % 4) == 0, 1, 4'd3, 0, "R3");
    // R7: one-cycle pulses at ratio 8
    for (int i = 0; i < 30; i++) step(1, 0, 0, 4'd7, 0, "R7");
    // R8: code change then source change mid-count
    for (int i = 0; i < 4; i++) step(1, 0, 0, 4'd5, 0, "R8");
    for (int i = 0; i < 12; i++) step(1, 0, 0, 4'd6, 0, "R8");
    for (int i = 0; i < 3; i++) step(1, 1, 0, 4'd6, 0, "R8");
    for (int i = 0; i < 16; i++) step(1, 1, 1, 4'd6, 0, "R8");
    // R9: clear mid-count, single and held
    for (int i = 0; i < 3; i++) step(1, 0, 0, 4'd4, 0, "R9");
    step(1, 0, 0, 4'd4, 1, "R9");
    for (int i = 0; i < 8; i++) step(1, 0, 0, 4'd4, 0, "R9");
    for (int i = 0; i < 4; i++) step(1, 0, 0, 4'd4, 1, "R9");
    for (int i = 0; i < 12; i++) step(1, 0, 0, 4'd4, 0, "R9");

    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule